// File: doc/BRIEF.md
# Accuracy-Configurable Segmented Adder

This block adds two N-bit operands and a carry-in, using K ripple-carry slices of L bits each. At each of the K-1 joints between adjacent slices, a run-time select bit decides which carry the upper slice receives:

- the exact ripple carry-out of the slice below it, or
- a one-bit guess taken from the generate term of that lower slice's top bit position.

With every select set to exact, the result is a normal binary sum. Clearing a select cuts the carry chain at that joint. The worst-case carry path then shrinks to one slice plus the guess logic, and a small error becomes possible.

The guess reuses the generate signal that the boundary bit cell already forms. The only added logic over a plain ripple adder is one two-way multiplexer per joint. Inside a slice, sum bits always follow the true ripple carry, starting from whatever carry the slice received. Each joint is set on its own, so any subset of joints can run approximate.

The block is purely combinational. A datapath that needs exact arithmetic sets all select bits. Error-tolerant workloads can clear some or all of them to trade accuracy for a shorter critical path.

Top module: `acsa_adder`

## Requirements
- R1: When every bit of `acc_mode_i` is 1, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` exactly, for every input.
- R2: Slice k covers bits k*L to k*L+L-1. At joint j (between slice j and slice j+1), `acc_mode_i[j]` selects the carry into slice j+1:
  - 1 selects the ripple carry-out of slice j;
  - 0 selects `a_i[j*L+L-1] & b_i[j*L+L-1]`.
- R3: When `a_i[j*L+L-1] == b_i[j*L+L-1]`, the value of `acc_mode_i[j]` has no effect on `sum_o` or `cout_o`.
- R4: For every slice, its L sum bits equal the low L bits of (its `a_i` field + its `b_i` field + the carry that slice received).
- R5: Slice 0 receives `cin_i`. `cout_o` is the exact ripple carry-out of the top slice, given the carry the top slice received.
- R6: When `acc_mode_i[j]` is 0, `sum_o` bits above joint j and `cout_o` do not depend on any operand bit below bit position j*L+L-1 or on `cin_i`.
- R7: N must be a multiple of L, and N/L must be at least 2. The mode vector has N/L-1 bits, with bit j belonging to joint j.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry into slice 0 |
| acc_mode_i | input | N/L-1 | Per-joint carry select, 1 = exact, 0 = predicted |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry-out of the top slice |

## Verification
The block holds no state, so a wrong carry selected or formed at a joint shows on the outputs within the same evaluation. It appears as a sum field above that joint that is off by exactly one, or as a changed `cout_o`. Random operands under random mode vectors expose such faults against a slice-by-slice reference. Directed cases cover two further points:
- a carry that an exact joint must pass and an approximate joint must drop;
- operand changes below an approximate joint that must leave the upper field untouched.

// File: rtl/acsa_pkg.sv
package acsa_pkg;

  typedef enum logic {
    JOINT_PREDICT = 1'b0,
    JOINT_EXACT   = 1'b1
  } joint_sel_e;

endpackage

// File: rtl/acsa_bitcell.sv
module acsa_bitcell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic gen_o,
  output logic prop_o,
  output logic sum_o
);

  always_comb begin
    gen_o  = a_i & b_i;
    prop_o = a_i ^ b_i;
    sum_o  = prop_o ^ c_i;
  end

endmodule

// File: rtl/acsa_slice.sv
module acsa_slice #(
  parameter int L = 8
) (
  input  logic [L-1:0] a_i,
  input  logic [L-1:0] b_i,
  input  logic         cin_i,
  output logic [L-1:0] sum_o,
  output logic         cout_o,
  output logic         cpred_o
);

  logic [L:0]   carry;
  logic [L-1:0] gen;
  logic [L-1:0] prop;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < L; i++) begin : g_bit
    acsa_bitcell u_cell (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .c_i    (carry[i]),
      .gen_o  (gen[i]),
      .prop_o (prop[i]),
      .sum_o  (sum_o[i])
    );
    assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
  end

  assign cout_o  = carry[L];
  // Prediction reuses the generate term of the slice's top bit cell.
  assign cpred_o = gen[L-1];

  always_comb begin
    AST_SLICE_SUM: assert ({cout_o, sum_o} ==
      ({1'b0, a_i} + {1'b0, b_i} + {{L{1'b0}}, cin_i})); // R4
  end

endmodule

// File: rtl/acsa_joint.sv
module acsa_joint
  import acsa_pkg::*;
(
  input  joint_sel_e sel_i,
  input  logic       exact_i,
  input  logic       pred_i,
  output logic       carry_o
);

  always_comb begin
    carry_o = (sel_i == JOINT_EXACT) ? exact_i : pred_i;
  end

endmodule

// File: rtl/acsa_adder.sv
module acsa_adder
  import acsa_pkg::*;
#(
  parameter int N = 32,
  parameter int L = 8
) (
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  input  logic           cin_i,
  input  logic [N/L-2:0] acc_mode_i,
  output logic [N-1:0]   sum_o,
  output logic           cout_o
);

  localparam int K = N / L;

  logic [K-1:0] slice_cin;
  logic [K-1:0] slice_cout;
  logic [K-1:0] slice_pred;

  assign slice_cin[0] = cin_i;

  for (genvar k = 0; k < K; k++) begin : g_slice
    acsa_slice #(.L(L)) u_slice (
      .a_i     (a_i[k*L +: L]),
      .b_i     (b_i[k*L +: L]),
      .cin_i   (slice_cin[k]),
      .sum_o   (sum_o[k*L +: L]),
      .cout_o  (slice_cout[k]),
      .cpred_o (slice_pred[k])
    );
  end

  for (genvar j = 0; j < K-1; j++) begin : g_joint
    acsa_joint u_joint (
      .sel_i   (joint_sel_e'(acc_mode_i[j])),
      .exact_i (slice_cout[j]),
      .pred_i  (slice_pred[j]),
      .carry_o (slice_cin[j+1])
    );

    always_comb begin
      if (a_i[j*L+L-1] == b_i[j*L+L-1]) begin
        AST_PRED_AGREES: assert (slice_pred[j] == slice_cout[j]); // R3
      end
      if (!acc_mode_i[j] && (a_i[j*L+L-1] != b_i[j*L+L-1])) begin
        AST_PRED_BLOCKS: assert (slice_cin[j+1] == 1'b0); // R2
      end
    end
  end

  assign cout_o = slice_cout[K-1];

  always_comb begin
    if (&acc_mode_i) begin
      AST_EXACT_SUM: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i})); // R1
    end
  end

endmodule

// File: tb/tb_acsa_adder.sv
module tb_acsa_adder;

  localparam int N = 32;
  localparam int L = 8;
  localparam int K = N / L;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk;
  logic [N-1:0] a, b;
  logic cin;
  logic [K-2:0] mode;
  logic [N-1:0] sum;
  logic cout;

  int n_tests;
  int n_fail;
  bit done;

  acsa_adder #(.N(N), .L(L)) dut (
    .a_i        (a),
    .b_i        (b),
    .cin_i      (cin),
    .acc_mode_i (mode),
    .sum_o      (sum),
    .cout_o     (cout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y,
                                         input logic c, input logic [K-2:0] m);
    logic [N:0] r;
    logic carry;
    logic [L:0] part;
    r = '0;
    carry = c;
    for (int k = 0; k < K; k++) begin
      part = {1'b0, x[k*L +: L]} + {1'b0, y[k*L +: L]} + {{L{1'b0}}, carry};
      r[k*L +: L] = part[L-1:0];
      if (k < K-1) carry = m[k] ? part[L] : (x[k*L+L-1] & y[k*L+L-1]);
      else r[N] = part[L];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [N:0] got, input logic [N:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y,
                       input logic c, input logic [K-2:0] m);
    @(posedge clk);
    a = x; b = y; cin = c; mode = m;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < WATCHDOG_CYCLES; cyc++) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [N:0] r0, r1;
    logic [N-1:0] x, y;
    logic [K-2:0] m;
    logic c;
    void'($urandom(32'd20240611));
    n_tests = 0; n_fail = 0; done = 1'b0;
    a = '0; b = '0; cin = 1'b0; mode = '0;

    // Quiet state: zero operands give zero result (R5)
    apply('0, '0, 1'b0, '0);
    check("R5 zero", {cout, sum}, '0);

    // R1: all-exact, extremes
    apply('1, '1, 1'b1, '1);
    check("R1 max", {cout, sum}, {1'b0, {N{1'b1}}} + {1'b0, {N{1'b1}}} + 1);
    apply('1, '0, 1'b1, '1);
    check("R1 carry through chain", {cout, sum}, {1'b1, {N{1'b0}}});

    // R5: cin reaches slice 0, stopped by predicted joint
    apply('1, '0, 1'b1, '0);
    check("R5 cin predicted joint", {cout, sum}, {1'b0, {(N-L){1'b1}}, {L{1'b0}}});
    apply(32'hFF00_0000, 32'h0100_0000, 1'b0, '1);
    check("R5 top cout", {cout, sum}, {1'b1, 32'h0000_0000});

    // R2: overflow of slice 0 with boundary bits unequal
    apply(32'h0000_00FF, 32'h0000_0001, 1'b0, 3'b000);
    check("R2 predict drops", {cout, sum}, 33'h0_0000_0000);
    apply(32'h0000_00FF, 32'h0000_0001, 1'b0, 3'b001);
    check("R2 exact passes", {cout, sum}, 33'h0_0000_0100);
    // R2: predicted carry 1 when both boundary bits set
    apply(32'h0000_0080, 32'h0000_0080, 1'b0, 3'b000);
    check("R2 predict gen", {cout, sum}, 33'h0_0000_0100);

    // R3: equal boundary bits make mode irrelevant
    for (int i = 0; i < 200; i++) begin
      x = $urandom; y = $urandom; c = 1'($urandom);
      for (int j = 0; j < K-1; j++) y[j*L+L-1] = x[j*L+L-1];
      apply(x, y, c, '0);
      r0 = {cout, sum};
      apply(x, y, c, '1);
      r1 = {cout, sum};
      check("R3 mode no effect", r0, r1);
    end

    // R6: approximate joint isolates upper slices from lower bits
    for (int i = 0; i < 100; i++) begin
      x = $urandom; y = $urandom; m = 3'($urandom); m[0] = 1'b0;
      apply(x, y, 1'b0, m);
      r0 = {cout, sum};
      x[L-2:0] = 7'($urandom); y[L-2:0] = 7'($urandom);
      apply(x, y, 1'b1, m);
      r1 = {cout, sum};
      check("R6 upper isolated", {r1[N:L]}, {r0[N:L]});
    end

    // R1 random all-exact against native addition
    for (int i = 0; i < 500; i++) begin
      x = $urandom; y = $urandom; c = 1'($urandom);
      apply(x, y, c, '1);
      check("R1 random exact", {cout, sum}, {1'b0, x} + {1'b0, y} + {{N{1'b0}}, c});
    end

    // R4 / R7: random modes against slice-level reference
    for (int i = 0; i < 2000; i++) begin
      x = $urandom; y = $urandom; c = 1'($urandom); m = 3'($urandom);
      apply(x, y, c, m);
      check("R4 R7 random mode", {cout, sum}, ref_add(x, y, c, m));
    end

    finish_run();
  end

endmodule